// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that walks a chain of descriptors in system memory and moves the bytes each one names from a system address to a device address. Software sets the mode, loads the address of the first descriptor and then writes enable together with start into the control/status register. The channel reads the four descriptor words one at a time over a request/grant read port. It then moves the byte count in beats over a second request/grant port and follows the next pointer until it reaches a descriptor whose next word carries the end-of-chain flag. Completion is reported by a sticky done bit, and a level interrupt is raised when the interrupt enable is set.

The controller is built around four named states. `S_IDLE` leaves on a start write, to `S_FETCH` in chain mode or to `S_MOVE` in single-block mode. `S_FETCH` issues four sequential reads, goes to `S_MOVE` after the fourth word, and goes back to `S_IDLE` on a read error. `S_MOVE` issues beats until the count is used up, or goes straight on when the count is zero, and then enters `S_ADVANCE`. `S_ADVANCE` returns to `S_FETCH` when the chain continues and to `S_IDLE`, setting done, when it ends. An abort write sends any state to `S_IDLE`.

Top module: `dmac_chan`

## Requirements
- R1: After reset every readable register (pointer 0, control/status 1, mode 2, system address 3, device address 4, count 5) reads 0, `irq` is low and neither request is raised.
- R2: A control/status write with enable (bit 0) and start (bit 1) both 1 while idle starts the channel. Start written without enable starts nothing and leaves enable at 0. Enable stays 1 for as long as the channel is busy (bit 6).
- R3: In chain mode the descriptor is read as four words at pointer, pointer+4, +8 and +12, holding in that order the system address, device address, byte count and next pointer.
- R4: Data moves in beats of min(4, remaining) bytes. The system and device addresses each advance by the beat size, and only one port requests at a time. A descriptor with a count of 0 makes no beat.
- R5: When bit 0 of the next word is 0, the following descriptor is fetched from the next word with its low 4 bits cleared, and the pointer register then shows that address. When bit 0 is 1 the descriptor is the last one. Descriptor-done (bit 4) sets after each descriptor.
- R6: At the end of the chain done (bit 3) sets and enable stays 1. Writing 1 to done or descriptor-done clears it. A write of those bits with enable 0 while idle turns the channel off.
- R7: `irq` is high exactly while done is set and the interrupt enable (mode bit 1) is 1.
- R8: Writing abort (bit 2) stops the channel at once. Enable reads 0, done stays 0, no interrupt is raised and both requests drop.
- R9: A read error during a fetch sets error (bit 5), clears enable, halts the channel and produces no beat from that descriptor.
- R10: With chain mode (mode bit 0) at 0, a start moves the bytes named by the system address, device address and count registers without any descriptor read, then sets done.
- R11: Writes to the pointer, address, count and mode registers while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_gnt | input | 1 | Read grant; data and error valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 1 | Read error |
| move_req | output | 1 | Data beat request |
| move_sys_addr | output | 32 | System address of the beat |
| move_dev_addr | output | 32 | Device address of the beat |
| move_bytes | output | 3 | Bytes in the beat (1 to 4) |
| move_gnt | input | 1 | Beat accepted |
| irq | output | 1 | Level transfer-done interrupt |

## Verification
The chain is run with a single descriptor whose odd count ends in a short beat, and with a three-descriptor chain that holds a zero-count descriptor and a next pointer with stray flag bits. Together these separate correct beat sizing, skipping and pointer masking from off-by-one and flag-leak faults. The grant patterns are varied between always-grant and every-other-cycle, so a design that moves on without a grant shows up as a mismatch in the order of requests. Single-block mode, a start without enable, an abort during a stalled beat (with pointer and mode writes attempted while busy) and a read error in the middle of a fetch each test one exit path of the state machine. The outcome of each is read back through the registers and `irq`.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_MOVE,
        S_ADVANCE
    } dmac_state_e;

    localparam logic [2:0] RA_DPTR = 3'd0;
    localparam logic [2:0] RA_CSR  = 3'd1;
    localparam logic [2:0] RA_MODE = 3'd2;
    localparam logic [2:0] RA_SYS  = 3'd3;
    localparam logic [2:0] RA_DEV  = 3'd4;
    localparam logic [2:0] RA_CNT  = 3'd5;

    localparam int CSR_EN    = 0;
    localparam int CSR_START = 1;
    localparam int CSR_ABORT = 2;
    localparam int CSR_DONE  = 3;
    localparam int CSR_DDONE = 4;
    localparam int CSR_ERR   = 5;
    localparam int CSR_BUSY  = 6;

    localparam int MODE_CHAIN = 0;
    localparam int MODE_IE    = 1;

    localparam logic [1:0] W_SYS = 2'd0;
    localparam logic [1:0] W_DEV = 2'd1;
    localparam logic [1:0] W_CNT = 2'd2;
    localparam logic [1:0] W_NXT = 2'd3;
endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        chain,
    input  logic        mem_gnt,
    input  logic        mem_rerr,
    input  logic        move_gnt,
    input  logic        cnt_zero,
    input  logic        cnt_last,
    input  logic        eoc,
    output dmac_state_e state,
    output logic [1:0]  widx,
    output logic        mem_req,
    output logic        move_req,
    output logic        load_word,
    output logic        beat_done,
    output logic        follow_next,
    output logic        set_done,
    output logic        set_ddone,
    output logic        set_err
);
    dmac_state_e state_nxt;
    logic [1:0]  widx_nxt;
    logic        more;

    assign more = chain && !eoc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            widx  <= 2'd0;
        end else begin
            state <= state_nxt;
            widx  <= widx_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        widx_nxt  = widx;
        if (abort) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state_nxt = chain ? S_FETCH : S_MOVE;
                        widx_nxt  = 2'd0;
                    end
                end
                S_FETCH: begin
                    if (mem_gnt) begin
                        if (mem_rerr)
                            state_nxt = S_IDLE;
                        else if (widx == W_NXT)
                            state_nxt = S_MOVE;
                        else
                            widx_nxt = widx + 2'd1;
                    end
                end
                S_MOVE: begin
                    if (cnt_zero || (move_gnt && cnt_last))
                        state_nxt = S_ADVANCE;
                end
                S_ADVANCE: begin
                    if (more) begin
                        state_nxt = S_FETCH;
                        widx_nxt  = 2'd0;
                    end else begin
                        state_nxt = S_IDLE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req     = (state == S_FETCH);
        move_req    = (state == S_MOVE) && !cnt_zero;
        load_word   = mem_req && mem_gnt && !mem_rerr && !abort;
        set_err     = mem_req && mem_gnt && mem_rerr && !abort;
        beat_done   = move_req && move_gnt && !abort;
        set_ddone   = (state == S_ADVANCE) && !abort;
        follow_next = set_ddone && more;
        set_done    = set_ddone && !more;
    end
endmodule

// File: rtl/dmac_addr.sv
module dmac_addr
    import dmac_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BEAT_BYTES = 4,
    parameter int EOC_BIT    = 0,
    parameter int ALIGN_BITS = 4,
    localparam int BW        = $clog2(BEAT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dptr,
    input  logic          wr_sys,
    input  logic          wr_dev,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          load_word,
    input  logic [1:0]    widx,
    input  logic [DW-1:0] fetch_data,
    input  logic          beat_done,
    input  logic          follow_next,
    output logic [DW-1:0] dptr,
    output logic [DW-1:0] sys_addr,
    output logic [DW-1:0] dev_addr,
    output logic [DW-1:0] count,
    output logic [BW-1:0] beat_bytes,
    output logic          cnt_zero,
    output logic          cnt_last,
    output logic          eoc
);
    localparam logic [DW-1:0] BEAT_MAX   = DW'(BEAT_BYTES);
    localparam logic [DW-1:0] ALIGN_MASK = ~((DW'(1) << ALIGN_BITS) - DW'(1));

    logic [DW-1:0] nxt;
    logic [DW-1:0] step;

    assign beat_bytes = (count < BEAT_MAX) ? count[BW-1:0] : BEAT_MAX[BW-1:0];
    assign step       = DW'(beat_bytes);
    assign cnt_zero   = (count == '0);
    assign cnt_last   = (count <= BEAT_MAX);
    assign eoc        = nxt[EOC_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dptr     <= '0;
            sys_addr <= '0;
            dev_addr <= '0;
            count    <= '0;
            nxt      <= '0;
        end else begin
            if (wr_dptr)
                dptr <= wdata;
            else if (follow_next)
                dptr <= nxt & ALIGN_MASK;

            if (wr_sys)
                sys_addr <= wdata;
            else if (load_word && widx == W_SYS)
                sys_addr <= fetch_data;
            else if (beat_done)
                sys_addr <= sys_addr + step;

            if (wr_dev)
                dev_addr <= wdata;
            else if (load_word && widx == W_DEV)
                dev_addr <= fetch_data;
            else if (beat_done)
                dev_addr <= dev_addr + step;

            if (wr_cnt)
                count <= wdata;
            else if (load_word && widx == W_CNT)
                count <= fetch_data;
            else if (beat_done)
                count <= count - step;

            if (load_word && widx == W_NXT)
                nxt <= fetch_data;
        end
    end
endmodule

// File: rtl/dmac_status.sv
module dmac_status
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_we,
    input  logic [5:0] csr_bits,
    input  logic       mode_we,
    input  logic [1:0] mode_bits,
    input  logic       busy,
    input  logic       set_done,
    input  logic       set_ddone,
    input  logic       set_err,
    output logic       en,
    output logic       done,
    output logic       ddone,
    output logic       err,
    output logic       chain,
    output logic       ie,
    output logic       start,
    output logic       abort,
    output logic       irq
);
    assign abort = csr_we && csr_bits[CSR_ABORT];
    assign start = csr_we && csr_bits[CSR_EN] && csr_bits[CSR_START] && !csr_bits[CSR_ABORT] && !busy;
    assign irq   = done && ie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            done  <= 1'b0;
            ddone <= 1'b0;
            err   <= 1'b0;
            chain <= 1'b0;
            ie    <= 1'b0;
        end else begin
            if (abort || set_err)
                en <= 1'b0;
            else if (csr_we && !busy)
                en <= csr_bits[CSR_EN];

            if (set_done)
                done <= 1'b1;
            else if (csr_we && csr_bits[CSR_DONE])
                done <= 1'b0;

            if (set_ddone)
                ddone <= 1'b1;
            else if (csr_we && csr_bits[CSR_DDONE])
                ddone <= 1'b0;

            if (set_err)
                err <= 1'b1;
            else if (csr_we && csr_bits[CSR_ERR])
                err <= 1'b0;

            if (mode_we && !busy) begin
                chain <= mode_bits[MODE_CHAIN];
                ie    <= mode_bits[MODE_IE];
            end
        end
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BEAT_BYTES = 4,
    parameter int EOC_BIT    = 0,
    parameter int ALIGN_BITS = 4,
    localparam int BW        = $clog2(BEAT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rerr,
    output logic          move_req,
    output logic [DW-1:0] move_sys_addr,
    output logic [DW-1:0] move_dev_addr,
    output logic [BW-1:0] move_bytes,
    input  logic          move_gnt,
    output logic          irq
);
    dmac_state_e   state;
    logic [1:0]    widx;
    logic          busy;
    logic          wr_dptr, wr_sys, wr_dev, wr_cnt, csr_we, mode_we;
    logic          start, abort, en, done, ddone, err, chain, ie;
    logic          load_word, beat_done, follow_next;
    logic          set_done, set_ddone, set_err;
    logic          cnt_zero, cnt_last, eoc;
    logic [DW-1:0] dptr, sys_addr, dev_addr, count;

    assign busy    = (state != S_IDLE);
    assign csr_we  = reg_we && (reg_addr == RA_CSR);
    assign mode_we = reg_we && (reg_addr == RA_MODE);
    assign wr_dptr = reg_we && (reg_addr == RA_DPTR) && !busy;
    assign wr_sys  = reg_we && (reg_addr == RA_SYS) && !busy;
    assign wr_dev  = reg_we && (reg_addr == RA_DEV) && !busy;
    assign wr_cnt  = reg_we && (reg_addr == RA_CNT) && !busy;

    assign mem_addr      = dptr + DW'({widx, 2'b00});
    assign move_sys_addr = sys_addr;
    assign move_dev_addr = dev_addr;

    dmac_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_bits  (reg_wdata[5:0]),
        .mode_we   (mode_we),
        .mode_bits (reg_wdata[1:0]),
        .busy      (busy),
        .set_done  (set_done),
        .set_ddone (set_ddone),
        .set_err   (set_err),
        .en        (en),
        .done      (done),
        .ddone     (ddone),
        .err       (err),
        .chain     (chain),
        .ie        (ie),
        .start     (start),
        .abort     (abort),
        .irq       (irq)
    );

    dmac_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .abort       (abort),
        .chain       (chain),
        .mem_gnt     (mem_gnt),
        .mem_rerr    (mem_rerr),
        .move_gnt    (move_gnt),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .eoc         (eoc),
        .state       (state),
        .widx        (widx),
        .mem_req     (mem_req),
        .move_req    (move_req),
        .load_word   (load_word),
        .beat_done   (beat_done),
        .follow_next (follow_next),
        .set_done    (set_done),
        .set_ddone   (set_ddone),
        .set_err     (set_err)
    );

    dmac_addr #(
        .DW         (DW),
        .BEAT_BYTES (BEAT_BYTES),
        .EOC_BIT    (EOC_BIT),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_dptr     (wr_dptr),
        .wr_sys      (wr_sys),
        .wr_dev      (wr_dev),
        .wr_cnt      (wr_cnt),
        .wdata       (reg_wdata),
        .load_word   (load_word),
        .widx        (widx),
        .fetch_data  (mem_rdata),
        .beat_done   (beat_done),
        .follow_next (follow_next),
        .dptr        (dptr),
        .sys_addr    (sys_addr),
        .dev_addr    (dev_addr),
        .count       (count),
        .beat_bytes  (move_bytes),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .eoc         (eoc)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_DPTR: reg_rdata = dptr;
            RA_CSR: begin
                reg_rdata[CSR_EN]    = en;
                reg_rdata[CSR_DONE]  = done;
                reg_rdata[CSR_DDONE] = ddone;
                reg_rdata[CSR_ERR]   = err;
                reg_rdata[CSR_BUSY]  = busy;
            end
            RA_MODE: begin
                reg_rdata[MODE_CHAIN] = chain;
                reg_rdata[MODE_IE]    = ie;
            end
            RA_SYS:  reg_rdata = sys_addr;
            RA_DEV:  reg_rdata = dev_addr;
            RA_CNT:  reg_rdata = count;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk
    import dmac_pkg::*;
#(
    parameter int BEAT_BYTES = 4,
    parameter int BW         = 3
) (
    input logic        clk,
    input logic        rst_n,
    input dmac_state_e state,
    input logic [1:0]  widx,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_rerr,
    input logic [31:0] mem_addr,
    input logic        move_req,
    input logic [BW-1:0] move_bytes,
    input logic        abort,
    input logic        busy,
    input logic        en,
    input logic        done
);
    p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !move_req);

    p_beat_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        move_req |-> (move_bytes != '0 && move_bytes <= BW'(BEAT_BYTES)));

    p_fetch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !mem_rerr && !abort && widx != 2'd3)
        |=> (mem_req && mem_addr == $past(mem_addr) + 32'd4));

    p_busy_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);

    p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && !en && !mem_req && !move_req));

    p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_rerr && !abort) |=> (!busy && !en));

    p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == S_ADVANCE && en));
endmodule

bind dmac_chan dmac_chan_chk #(
    .BEAT_BYTES (BEAT_BYTES),
    .BW         (BW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .widx       (widx),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rerr   (mem_rerr),
    .mem_addr   (mem_addr),
    .move_req   (move_req),
    .move_bytes (move_bytes),
    .abort      (abort),
    .busy       (busy),
    .en         (en),
    .done       (done)
);

// File: tb/dmac_chan_tb.sv
`timescale 1ns/1ps
module dmac_chan_tb;
    import dmac_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_rerr = 1'b0;
    logic        move_req;
    logic [31:0] move_sys_addr, move_dev_addr;
    logic [2:0]  move_bytes;
    logic        move_gnt = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    dmac_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr), .move_req(move_req), .move_sys_addr(move_sys_addr),
        .move_dev_addr(move_dev_addr), .move_bytes(move_bytes),
        .move_gnt(move_gnt), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mem_gmode = 0;
    int mv_gmode = 0;
    bit err_on = 0;
    bit finished = 0;
    logic [31:0] err_addr = 32'd0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] q_rd [$];
    logic [31:0] q_sys [$];
    logic [31:0] q_dev [$];
    logic [2:0]  q_len [$];
    logic [31:0] e_addr;
    logic [95:0] e_mv;
    logic [31:0] rv;

    task automatic chk(string req, string what, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit grant(int mode);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (cyc % 2) == 0;
        return 1'b0;
    endfunction

    // per-clock comparison of both ports against the reference queues
    always @(negedge clk) begin
        cyc++;
        mem_gnt = 1'b0; mem_rerr = 1'b0; mem_rdata = 32'd0; move_gnt = 1'b0;
        if (rst_n) begin
            if (mem_req && grant(mem_gmode)) begin
                mem_gnt = 1'b1;
                e_addr = (q_rd.size() != 0) ? q_rd.pop_front() : 32'hFFFF_FFFF;
                chk("R3", "read address", 96'(mem_addr), 96'(e_addr));
                if (err_on && mem_addr == err_addr) mem_rerr = 1'b1;
                else if (mem.exists(mem_addr)) mem_rdata = mem[mem_addr];
            end
            if (move_req && grant(mv_gmode)) begin
                move_gnt = 1'b1;
                if (q_len.size() != 0)
                    e_mv = {q_sys.pop_front(), q_dev.pop_front(), 29'd0, q_len.pop_front()};
                else
                    e_mv = '1;
                chk("R4", "beat sys/dev/len", {move_sys_addr, move_dev_addr, 29'd0, move_bytes}, e_mv);
            end
        end
    end

    task automatic plan_moves(logic [31:0] s, logic [31:0] d, logic [31:0] n);
        while (n != 0) begin
            logic [31:0] b;
            b = (n < 4) ? n : 32'd4;
            q_sys.push_back(s); q_dev.push_back(d); q_len.push_back(b[2:0]);
            s += b; d += b; n -= b;
        end
    endtask

    task automatic plan_chain(logic [31:0] head);
        logic [31:0] p;
        bit last;
        p = head; last = 0;
        while (!last) begin
            logic [31:0] w [4];
            for (int i = 0; i < 4; i++) begin
                q_rd.push_back(p + 32'(4 * i));
                if (err_on && p + 32'(4 * i) == err_addr) return;
                w[i] = mem[p + 32'(4 * i)];
            end
            plan_moves(w[0], w[1], w[2]);
            last = w[3][0];
            p = {w[3][31:4], 4'b0};
        end
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] s, logic [31:0] d, logic [31:0] n, logic [31:0] nx);
        mem[a] = s; mem[a + 4] = d; mem[a + 8] = n; mem[a + 12] = nx;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            rd(RA_CSR, rv);
            n++;
        end while (rv[CSR_BUSY] && n < 2000);
        if (n >= 2000) chk("R6", "channel never went idle", 96'd1, 96'd0);
    endtask

    task automatic queues_empty(string req);
        chk(req, "reads left over", 96'(q_rd.size()), 96'd0);
        chk(req, "beats left over", 96'(q_len.size()), 96'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), rv);
            chk("R1", "reset register", 96'(rv), 96'd0);
        end
        chk("R1", "reset irq", 96'(irq), 96'd0);

        // R2 start without enable does nothing
        wr(RA_MODE, 32'h3);
        wr(RA_CSR, 32'h2);
        repeat (6) @(negedge clk);
        rd(RA_CSR, rv);
        chk("R2", "start without enable", 96'(rv), 96'd0);

        // single descriptor, odd count, always grant
        put_desc(32'h100, 32'h1000, 32'h8000, 32'd10, 32'h1);
        wr(RA_DPTR, 32'h100);
        plan_chain(32'h100);
        wr(RA_CSR, 32'h3);
        wait_idle();
        queues_empty("R3");
        rd(RA_CSR, rv); chk("R6", "done with enable kept", 96'(rv), 96'h19);
        chk("R7", "irq with done and ie", 96'(irq), 96'd1);
        rd(RA_SYS, rv); chk("R4", "final sys address", 96'(rv), 96'h100A);
        rd(RA_DEV, rv); chk("R4", "final dev address", 96'(rv), 96'h800A);
        rd(RA_CNT, rv); chk("R4", "final count", 96'(rv), 96'd0);

        // R6 write-one-to-clear without enable turns off
        wr(RA_CSR, 32'h18);
        rd(RA_CSR, rv); chk("R6", "cleared and off", 96'(rv), 96'd0);
        chk("R7", "irq after clear", 96'(irq), 96'd0);

        // three descriptors, zero count in the middle, stray flag bits, alternating grants
        mem_gmode = 1; mv_gmode = 1;
        put_desc(32'h200, 32'h2000, 32'h9000, 32'd7, 32'h240);
        put_desc(32'h240, 32'h2800, 32'h9800, 32'd0, 32'h28E);
        put_desc(32'h280, 32'h3004, 32'hA000, 32'd9, 32'h1);
        wr(RA_DPTR, 32'h200);
        plan_chain(32'h200);
        wr(RA_CSR, 32'h3);
        wait_idle();
        queues_empty("R5");
        rd(RA_DPTR, rv); chk("R5", "pointer on last descriptor", 96'(rv), 96'h280);
        rd(RA_SYS, rv); chk("R4", "sys after skip chain", 96'(rv), 96'h300D);
        rd(RA_CSR, rv); chk("R5", "done and descriptor done", 96'(rv), 96'h19);
        wr(RA_CSR, 32'h18);

        // R7 interrupt disabled
        mem_gmode = 0; mv_gmode = 0;
        wr(RA_MODE, 32'h1);
        put_desc(32'h300, 32'h5000, 32'hC000, 32'd4, 32'h1);
        wr(RA_DPTR, 32'h300);
        plan_chain(32'h300);
        wr(RA_CSR, 32'h3);
        wait_idle();
        rd(RA_CSR, rv); chk("R7", "done set with ie off", 96'(rv), 96'h19);
        chk("R7", "irq stays low with ie off", 96'(irq), 96'd0);
        wr(RA_CSR, 32'h18);

        // R10 single-block mode
        wr(RA_MODE, 32'h2);
        wr(RA_SYS, 32'h4001);
        wr(RA_DEV, 32'hB003);
        wr(RA_CNT, 32'd6);
        plan_moves(32'h4001, 32'hB003, 32'd6);
        wr(RA_CSR, 32'h3);
        wait_idle();
        queues_empty("R10");
        rd(RA_CSR, rv); chk("R10", "single-block done", 96'(rv), 96'h19);
        chk("R10", "single-block irq", 96'(irq), 96'd1);
        rd(RA_SYS, rv); chk("R10", "single-block sys", 96'(rv), 96'h4007);
        wr(RA_CSR, 32'h18);

        // R8 abort during stalled beat, R11 writes while busy
        mv_gmode = 2;
        wr(RA_MODE, 32'h3);
        put_desc(32'h400, 32'h6000, 32'hD000, 32'd64, 32'h1);
        wr(RA_DPTR, 32'h400);
        plan_chain(32'h400);
        wr(RA_CSR, 32'h3);
        repeat (12) @(negedge clk);
        rd(RA_CSR, rv); chk("R2", "busy with enable", 96'(rv), 96'h41);
        wr(RA_DPTR, 32'hDEAD0000);
        wr(RA_MODE, 32'h0);
        wr(RA_CNT, 32'd1);
        rd(RA_DPTR, rv); chk("R11", "pointer write ignored", 96'(rv), 96'h400);
        rd(RA_MODE, rv); chk("R11", "mode write ignored", 96'(rv), 96'h3);
        rd(RA_CNT, rv); chk("R11", "count write ignored", 96'(rv), 96'd64);
        wr(RA_CSR, 32'h4);
        q_sys.delete(); q_dev.delete(); q_len.delete();
        mv_gmode = 0;
        rd(RA_CSR, rv); chk("R8", "abort clears enable", 96'(rv), 96'd0);
        repeat (6) @(negedge clk);
        chk("R8", "no irq after abort", 96'(irq), 96'd0);
        chk("R8", "requests dropped", 96'({mem_req, move_req}), 96'd0);
        queues_empty("R8");

        // R9 read error on the third word of the second descriptor
        err_on = 1; err_addr = 32'h548;
        put_desc(32'h500, 32'h7000, 32'hE000, 32'd5, 32'h540);
        put_desc(32'h540, 32'h7800, 32'hE800, 32'd8, 32'h1);
        wr(RA_DPTR, 32'h500);
        plan_chain(32'h500);
        wr(RA_CSR, 32'h3);
        wait_idle();
        queues_empty("R9");
        rd(RA_CSR, rv); chk("R9", "error halt status", 96'(rv), 96'h30);
        chk("R9", "no irq on error", 96'(irq), 96'd0);
        err_on = 0;
        wr(RA_CSR, 32'h30);
        rd(RA_CSR, rv); chk("R9", "error cleared", 96'(rv), 96'd0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule